// File: doc/BRIEF.md
# Quadrature Encoder Decoder

This block turns the two phase signals and the index signal of an incremental rotary or linear encoder into a signed position count and a direction indication. Each input can be inverted on its own. The two phases can be exchanged. The index can be taken from the phase B pin instead of its own pin. Every input then passes through a glitch filter whose length is programmable, and only after that is it decoded.

Three decode styles are available. Full quadrature counts every edge of both phases. Phase-A-only counting steps on phase A edges alone. Pass-through mode treats phase A as a count strobe and phase B as a direction level. The decoder raises three sticky event flags: index seen, direction reversed and quadrature error. Each flag has an interrupt mask bit that is set and cleared through separate strobes. A rising edge on the filtered index can return the position to zero.

Top module: `qdec_top`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls, `pos_o` is 0, `stat_o` is 0 (flags clear, direction up), `irq_mask_o` is 0 and `irq_o` is low.
- R2: A change on a conditioned input is accepted only after it has held for `cfg_filt`+1 consecutive clock edges. A shorter excursion is discarded and has no effect on `pos_o`.
- R3: In full quadrature mode, every accepted edge of either phase moves `pos_o` by one. With {A,B} stepping 00→10→11→01→00 (A leading) the count goes up and `dir_o` is 0. The reverse order counts down and `dir_o` is 1.
- R4: With `cfg_edge_a_only` high, only phase A edges change `pos_o`. The step is up when A differs from B after the edge, otherwise down. Phase B edges have no effect on the count.
- R5: With `cfg_transparent` high (this has priority over R4), each rising edge of filtered A moves `pos_o` by one: up when B is 0, down when B is 1. Falling A edges and B edges do not count.
- R6: `cfg_inv_a`, `cfg_inv_b` and `cfg_inv_idx` each invert one input before filtering and decoding.
- R7: `cfg_swap` exchanges the phase A and phase B pins after inversion.
- R8: With `cfg_idx_from_b` high, the index signal is taken from the `phb_i` pin, and `idx_i` is ignored.
- R9: With `cfg_index_en` high, a rising edge of the filtered index sets `pos_o` to 0 (this wins over a step in the same cycle) and sets status bit 0. With it low, the index has no effect on the count or on the flag.
- R10: When both filtered phases change in the same cycle (in full or phase-A-only mode), `pos_o` does not change and status bit 2 is set.
- R11: Status bit 1 is set when a step's direction differs from the direction of the previous step. `stat_o[8]` always equals `dir_o`.
- R12: A high `stat_rd` clears status bits 2..0 on that clock edge. An event on the same edge still sets its flag.
- R13: `irq_en_set` sets mask bits and `irq_en_clr` clears them; clear wins when both are high. `irq_o` is high exactly when some status bit in 2..0 and its mask bit are both 1.
- R14: `pos_o` wraps modulo 2^POS_W: one down step from 0 gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pha_i | input | 1 | Phase A pin |
| phb_i | input | 1 | Phase B pin |
| idx_i | input | 1 | Index pin |
| cfg_inv_a | input | 1 | Invert phase A |
| cfg_inv_b | input | 1 | Invert phase B |
| cfg_inv_idx | input | 1 | Invert index |
| cfg_swap | input | 1 | Exchange phases A and B |
| cfg_idx_from_b | input | 1 | Take index from the phase B pin |
| cfg_edge_a_only | input | 1 | Count phase A edges only |
| cfg_transparent | input | 1 | A is count strobe, B is direction |
| cfg_index_en | input | 1 | Index resets position and raises flag |
| cfg_filt | input | 6 | Filter length minus one |
| irq_en_set | input | 3 | Set interrupt mask bits |
| irq_en_clr | input | 3 | Clear interrupt mask bits |
| stat_rd | input | 1 | Status read strobe, clears flags |
| pos_o | output | POS_W | Position count |
| dir_o | output | 1 | Direction, 0 up, 1 down |
| stat_o | output | 9 | Bit 0 index, bit 1 direction change, bit 2 quadrature error, bit 8 direction |
| irq_mask_o | output | 3 | Interrupt mask |
| irq_o | output | 1 | Interrupt request |

## Verification
An input driven just after a falling clock edge is first sampled on the next rising edge, which is called edge k. The filter accepts it on edge k+`cfg_filt`. Position, direction and flags follow one edge later, so they are due `cfg_filt`+2 rising edges after the drive. The bench drives on falling edges, waits exactly that many rising edges and samples on the following falling edge. The filter-boundary test also samples one edge early, to confirm that nothing moved before that point. Mask and read strobes act on the next rising edge and are checked on the falling edge right after it.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    localparam int FILT_W       = 6;
    localparam int NUM_FLAGS    = 3;
    localparam int FLG_IDX      = 0;
    localparam int FLG_DIRCHG   = 1;
    localparam int FLG_QERR     = 2;
    localparam int STAT_DIR_BIT = 8;
    localparam int STAT_W       = STAT_DIR_BIT + 1;
    localparam int STAT_PAD_W   = STAT_DIR_BIT - NUM_FLAGS;

    // conditioned encoder signals, A in the top bit
    typedef struct packed {
        logic a;
        logic b;
        logic idx;
    } qsig_t;

    localparam int QSIG_W = $bits(qsig_t);

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        MODE_QUAD   = 2'd0,
        MODE_EDGE_A = 2'd1,
        MODE_PASS   = 2'd2
    } dmode_e;

    typedef struct packed {
        logic step;
        dir_e dir;
        logic qerr;
    } step_t;

    // direction of a single-phase transition, given the new phase levels
    function automatic dir_e quad_dir(input logic a_moved, input logic a, input logic b);
        if (a_moved)
            return (a ^ b) ? DIR_UP : DIR_DOWN;
        else
            return (a == b) ? DIR_UP : DIR_DOWN;
    endfunction

endpackage

// File: rtl/qdec_input_cond.sv
module qdec_input_cond
    import qdec_pkg::*;
(
    input  logic  pha_i,
    input  logic  phb_i,
    input  logic  idx_i,
    input  logic  inv_a,
    input  logic  inv_b,
    input  logic  inv_idx,
    input  logic  swap,
    input  logic  idx_from_b,
    output qsig_t sig_o
);

    logic a_pol;
    logic b_pol;
    logic idx_src;

    always_comb begin
        a_pol   = pha_i ^ inv_a;
        b_pol   = phb_i ^ inv_b;
        idx_src = idx_from_b ? phb_i : idx_i;

        sig_o.a   = swap ? b_pol : a_pol;
        sig_o.b   = swap ? a_pol : b_pol;
        sig_o.idx = idx_src ^ inv_idx;
    end

endmodule

// File: rtl/qdec_glitch_filter.sv
module qdec_glitch_filter
    import qdec_pkg::*;
#(
    parameter int CNT_W = FILT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] filt_len,
    input  qsig_t            raw_i,
    output qsig_t            filt_o
);

    logic [QSIG_W-1:0] raw_v;
    logic [QSIG_W-1:0] filt_v;

    assign raw_v  = raw_i;
    assign filt_o = qsig_t'(filt_v);

    for (genvar g = 0; g < QSIG_W; g++) begin : g_chan
        logic [CNT_W-1:0] hold_q;
        logic             level_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q  <= '0;
                level_q <= 1'b0;
            end else if (raw_v[g] == level_q) begin
                hold_q <= '0;
            end else if (hold_q == filt_len) begin
                level_q <= raw_v[g];
                hold_q  <= '0;
            end else begin
                hold_q <= hold_q + 1'b1;
            end
        end

        assign filt_v[g] = level_q;
    end

endmodule

// File: rtl/qdec_step_decoder.sv
module qdec_step_decoder
    import qdec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  dmode_e mode,
    input  qsig_t  cur_i,
    output step_t  step_o,
    output logic   idx_rise_o
);

    qsig_t prev_q;
    logic  a_moved;
    logic  b_moved;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cur_i;
    end

    assign a_moved    = cur_i.a ^ prev_q.a;
    assign b_moved    = cur_i.b ^ prev_q.b;
    assign idx_rise_o = cur_i.idx & ~prev_q.idx;

    always_comb begin
        step_o = '{step: 1'b0, dir: DIR_UP, qerr: 1'b0};
        case (mode)
            MODE_PASS: begin
                if (cur_i.a && !prev_q.a) begin
                    step_o.step = 1'b1;
                    step_o.dir  = cur_i.b ? DIR_DOWN : DIR_UP;
                end
            end
            MODE_EDGE_A: begin
                if (a_moved && b_moved) begin
                    step_o.qerr = 1'b1;
                end else if (a_moved) begin
                    step_o.step = 1'b1;
                    step_o.dir  = quad_dir(1'b1, cur_i.a, cur_i.b);
                end
            end
            default: begin
                if (a_moved && b_moved) begin
                    step_o.qerr = 1'b1;
                end else if (a_moved || b_moved) begin
                    step_o.step = 1'b1;
                    step_o.dir  = quad_dir(a_moved, cur_i.a, cur_i.b);
                end
            end
        endcase
    end

endmodule

// File: rtl/qdec_status.sv
module qdec_status
    import qdec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_FLAGS-1:0] ev_set,
    input  logic                 rd,
    input  logic [NUM_FLAGS-1:0] en_set,
    input  logic [NUM_FLAGS-1:0] en_clr,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic [NUM_FLAGS-1:0] mask_o,
    output logic                 irq_o
);

    logic [NUM_FLAGS-1:0] flags_q;
    logic [NUM_FLAGS-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            mask_q  <= '0;
        end else begin
            flags_q <= (rd ? '0 : flags_q) | ev_set;
            mask_q  <= (mask_q | en_set) & ~en_clr;
        end
    end

    assign flags_o = flags_q;
    assign mask_o  = mask_q;
    assign irq_o   = |(flags_q & mask_q);

endmodule

// File: rtl/qdec_top.sv
module qdec_top
    import qdec_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pha_i,
    input  logic                 phb_i,
    input  logic                 idx_i,
    input  logic                 cfg_inv_a,
    input  logic                 cfg_inv_b,
    input  logic                 cfg_inv_idx,
    input  logic                 cfg_swap,
    input  logic                 cfg_idx_from_b,
    input  logic                 cfg_edge_a_only,
    input  logic                 cfg_transparent,
    input  logic                 cfg_index_en,
    input  logic [FILT_W-1:0]    cfg_filt,
    input  logic [NUM_FLAGS-1:0] irq_en_set,
    input  logic [NUM_FLAGS-1:0] irq_en_clr,
    input  logic                 stat_rd,
    output logic [POS_W-1:0]     pos_o,
    output logic                 dir_o,
    output logic [STAT_W-1:0]    stat_o,
    output logic [NUM_FLAGS-1:0] irq_mask_o,
    output logic                 irq_o
);

    qsig_t                cond_sig;
    qsig_t                filt_sig;
    dmode_e               mode;
    step_t                step;
    logic                 idx_rise;
    logic                 idx_evt;
    logic [NUM_FLAGS-1:0] ev_set;
    logic [NUM_FLAGS-1:0] flags;
    logic [POS_W-1:0]     pos_q;
    dir_e                 dir_q;

    qdec_input_cond u_cond (
        .pha_i      (pha_i),
        .phb_i      (phb_i),
        .idx_i      (idx_i),
        .inv_a      (cfg_inv_a),
        .inv_b      (cfg_inv_b),
        .inv_idx    (cfg_inv_idx),
        .swap       (cfg_swap),
        .idx_from_b (cfg_idx_from_b),
        .sig_o      (cond_sig)
    );

    qdec_glitch_filter #(.CNT_W(FILT_W)) u_filt (
        .clk      (clk),
        .rst      (rst),
        .filt_len (cfg_filt),
        .raw_i    (cond_sig),
        .filt_o   (filt_sig)
    );

    assign mode = cfg_transparent ? MODE_PASS :
                  cfg_edge_a_only ? MODE_EDGE_A : MODE_QUAD;

    qdec_step_decoder u_dec (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .cur_i      (filt_sig),
        .step_o     (step),
        .idx_rise_o (idx_rise)
    );

    assign idx_evt = idx_rise & cfg_index_en;

    always_comb begin
        ev_set             = '0;
        ev_set[FLG_IDX]    = idx_evt;
        ev_set[FLG_DIRCHG] = step.step && (step.dir != dir_q);
        ev_set[FLG_QERR]   = step.qerr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            dir_q <= DIR_UP;
        end else begin
            if (step.step) begin
                dir_q <= step.dir;
                pos_q <= (step.dir == DIR_UP) ? pos_q + 1'b1 : pos_q - 1'b1;
            end
            if (idx_evt) pos_q <= '0;
        end
    end

    qdec_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .ev_set  (ev_set),
        .rd      (stat_rd),
        .en_set  (irq_en_set),
        .en_clr  (irq_en_clr),
        .flags_o (flags),
        .mask_o  (irq_mask_o),
        .irq_o   (irq_o)
    );

    assign pos_o  = pos_q;
    assign dir_o  = dir_q;
    assign stat_o = {dir_q, {STAT_PAD_W{1'b0}}, flags};

endmodule

// File: rtl/qdec_checker.sv
module qdec_checker
    import qdec_pkg::*;
#(
    parameter int POS_W = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [POS_W-1:0]     pos_o,
    input logic [STAT_W-1:0]    stat_o,
    input logic [NUM_FLAGS-1:0] irq_mask_o,
    input logic                 irq_o,
    input logic                 stat_rd,
    input logic [NUM_FLAGS-1:0] irq_en_clr,
    input logic [NUM_FLAGS-1:0] ev_set
);

    // R1: reset leaves a clean state
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pos_o == '0 && stat_o == '0 && irq_mask_o == '0));

    // R3: the count moves by at most one step or returns to zero
    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        (pos_o != $past(pos_o)) |->
            (pos_o == POS_W'($past(pos_o) + 1'b1) ||
             pos_o == POS_W'($past(pos_o) - 1'b1) ||
             pos_o == '0));

    // R9: index event returns the count to zero
    a_r9_index_zero: assert property (@(posedge clk) disable iff (rst)
        ev_set[FLG_IDX] |=> (pos_o == '0));

    // R10: quadrature error flags and does not count
    a_r10_qerr_flag: assert property (@(posedge clk) disable iff (rst)
        ev_set[FLG_QERR] |=> stat_o[FLG_QERR]);

    a_r10_qerr_hold: assert property (@(posedge clk) disable iff (rst)
        (ev_set[FLG_QERR] && !ev_set[FLG_IDX]) |=> $stable(pos_o));

    // R12: a read with no new events leaves all flags clear
    a_r12_read_clear: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && ev_set == '0) |=> (stat_o[NUM_FLAGS-1:0] == '0));

    // R13: interrupt only with a masked-in flag; clear strobe wins
    a_r13_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((stat_o[NUM_FLAGS-1:0] & irq_mask_o) != '0));

    a_r13_clr_wins: assert property (@(posedge clk) disable iff (rst)
        (irq_en_clr != '0) |=> ((irq_mask_o & $past(irq_en_clr)) == '0));

endmodule

bind qdec_top qdec_checker #(.POS_W(POS_W)) u_qdec_checker (
    .clk        (clk),
    .rst        (rst),
    .pos_o      (pos_o),
    .stat_o     (stat_o),
    .irq_mask_o (irq_mask_o),
    .irq_o      (irq_o),
    .stat_rd    (stat_rd),
    .irq_en_clr (irq_en_clr),
    .ev_set     (ev_set)
);

// File: tb/test_qdec_top.sv
module test_qdec_top;

    localparam int POS_W = 16;
    localparam int NVEC  = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pha = 1'b0, phb = 1'b0, idx = 1'b0;
    logic             cfg_inv_a = 0, cfg_inv_b = 0, cfg_inv_idx = 0, cfg_swap = 0;
    logic             cfg_idx_from_b = 0, cfg_edge_a_only = 0, cfg_transparent = 0;
    logic             cfg_index_en = 0;
    logic [5:0]       cfg_filt = 6'd1;
    logic [2:0]       irq_en_set = '0, irq_en_clr = '0;
    logic             stat_rd = 1'b0;
    logic [POS_W-1:0] pos;
    logic             dir;
    logic [8:0]       stat;
    logic [2:0]       mask;
    logic             irq;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    qdec_top #(.POS_W(POS_W)) i_qdec_top (
        .clk(clk), .rst(rst), .pha_i(pha), .phb_i(phb), .idx_i(idx),
        .cfg_inv_a(cfg_inv_a), .cfg_inv_b(cfg_inv_b), .cfg_inv_idx(cfg_inv_idx),
        .cfg_swap(cfg_swap), .cfg_idx_from_b(cfg_idx_from_b),
        .cfg_edge_a_only(cfg_edge_a_only), .cfg_transparent(cfg_transparent),
        .cfg_index_en(cfg_index_en), .cfg_filt(cfg_filt),
        .irq_en_set(irq_en_set), .irq_en_clr(irq_en_clr), .stat_rd(stat_rd),
        .pos_o(pos), .dir_o(dir), .stat_o(stat), .irq_mask_o(mask), .irq_o(irq)
    );

    // {A, B, expected dir, expected position}, full quadrature, filter 1
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 16'h0001},
        {1'b1, 1'b1, 1'b0, 16'h0002},
        {1'b0, 1'b1, 1'b0, 16'h0003},
        {1'b0, 1'b0, 1'b0, 16'h0004},
        {1'b0, 1'b1, 1'b1, 16'h0003},
        {1'b1, 1'b1, 1'b1, 16'h0002},
        {1'b1, 1'b0, 1'b1, 16'h0001},
        {1'b0, 1'b0, 1'b1, 16'h0000},
        {1'b0, 1'b1, 1'b1, 16'hFFFF},
        {1'b0, 1'b0, 1'b0, 16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        pha = 0; phb = 0; idx = 0;
        cfg_inv_a = 0; cfg_inv_b = 0; cfg_inv_idx = 0; cfg_swap = 0;
        cfg_idx_from_b = 0; cfg_edge_a_only = 0; cfg_transparent = 0;
        cfg_index_en = 0; cfg_filt = 6'd1;
        irq_en_set = '0; irq_en_clr = '0; stat_rd = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // drive pins, then wait until results are due (filter + 2 edges)
    task automatic drive(input logic a, input logic b, input logic i);
        @(negedge clk);
        pha = a; phb = b; idx = i;
        repeat (int'(cfg_filt) + 2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (int'(cfg_filt) + 3) @(negedge clk);
    endtask

    task automatic read_status();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pos", pos, 0);
        chk("R1 stat", stat, 0);
        chk("R1 mask", mask, 0);
        chk("R1 irq", irq, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pos after release", pos, 0);

        // R3 / R14: quadrature table
        for (int v = 0; v < NVEC; v++) begin
            drive(VEC[v][18], VEC[v][17], 1'b0);
            chk("R3 table pos", pos, VEC[v][15:0]);
            chk("R3 table dir", dir, VEC[v][16]);
        end
        chk("R11 stat dir bit mirrors dir", stat[8], dir);

        // R2: filter length and glitch rejection
        do_reset();
        cfg_filt = 6'd3;
        @(negedge clk);
        pha = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        pha = 1'b0;
        repeat (8) @(negedge clk);
        chk("R2 short pulse ignored", pos, 0);
        pha = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R2 not yet accepted", pos, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R2 accepted after filt+1", pos, 1);

        // R10 / R12 / R13: quadrature error, read clear, interrupt mask
        do_reset();
        drive(1'b1, 1'b1, 1'b0);
        chk("R10 qerr no count", pos, 0);
        chk("R10 qerr flag", stat[2:0], 3'b100);
        read_status();
        chk("R12 read clears", stat[2:0], 3'b000);
        @(negedge clk);
        irq_en_set = 3'b100;
        @(negedge clk);
        irq_en_set = 3'b000;
        chk("R13 mask set", mask, 3'b100);
        drive(1'b0, 1'b0, 1'b0);
        chk("R13 irq on masked flag", irq, 1);
        irq_en_clr = 3'b100;
        @(negedge clk);
        irq_en_clr = 3'b000;
        chk("R13 irq off after clear", irq, 0);
        chk("R13 flag kept", stat[2], 1);
        irq_en_set = 3'b001;
        irq_en_clr = 3'b001;
        @(negedge clk);
        irq_en_set = 3'b000;
        irq_en_clr = 3'b000;
        chk("R13 clear wins", mask, 3'b000);

        // R11: direction change flag
        do_reset();
        drive(1'b1, 1'b0, 1'b0);
        chk("R11 first up step no dirchg", stat[1], 0);
        drive(1'b0, 1'b0, 1'b0);
        chk("R11 reversal flags", stat[1], 1);
        chk("R11 dir down", dir, 1);
        chk("R11 stat bit 8", stat[8], 1);

        // R9: index reset enabled and disabled
        do_reset();
        cfg_index_en = 1'b1;
        drive(1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b1);
        chk("R9 index zeroes pos", pos, 0);
        chk("R9 index flag", stat[0], 1);
        read_status();
        drive(1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0);
        cfg_index_en = 1'b0;
        drive(1'b1, 1'b1, 1'b1);
        chk("R9 disabled index keeps pos", pos, 1);
        chk("R9 disabled index no flag", stat[0], 0);

        // R8: index from phase B pin, index wins over step
        do_reset();
        cfg_index_en = 1'b1;
        cfg_idx_from_b = 1'b1;
        drive(1'b1, 1'b0, 1'b0);
        chk("R8 step before index", pos, 1);
        drive(1'b1, 1'b1, 1'b0);
        chk("R8 index from B zeroes", pos, 0);
        chk("R8 index flag", stat[0], 1);

        // R6: inversion
        do_reset();
        @(negedge clk);
        cfg_inv_a = 1'b1;
        settle();
        chk("R6 invert A", pos, 1);
        cfg_inv_b = 1'b1;
        settle();
        chk("R6 invert B", pos, 2);
        cfg_index_en = 1'b1;
        cfg_inv_idx = 1'b1;
        settle();
        chk("R6 invert index", pos, 0);
        chk("R6 invert index flag", stat[0], 1);

        // R7: swap
        do_reset();
        cfg_swap = 1'b1;
        drive(1'b0, 1'b1, 1'b0);
        chk("R7 swapped B leads", pos, 1);

        // R4: phase A only
        do_reset();
        cfg_edge_a_only = 1'b1;
        drive(1'b1, 1'b0, 1'b0);
        chk("R4 A rise", pos, 1);
        drive(1'b1, 1'b1, 1'b0);
        chk("R4 B edge ignored", pos, 1);
        drive(1'b0, 1'b1, 1'b0);
        chk("R4 A fall", pos, 2);
        drive(1'b0, 1'b0, 1'b0);
        chk("R4 B edge ignored again", pos, 2);

        // R5: pass-through
        do_reset();
        cfg_transparent = 1'b1;
        cfg_edge_a_only = 1'b1;
        drive(1'b1, 1'b0, 1'b0);
        chk("R5 A rise up", pos, 1);
        drive(1'b0, 1'b0, 1'b0);
        chk("R5 A fall no count", pos, 1);
        drive(1'b0, 1'b1, 1'b0);
        chk("R5 B edge no count", pos, 1);
        drive(1'b1, 1'b1, 1'b0);
        chk("R5 A rise down", pos, 0);
        chk("R5 dir down", dir, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule